// File: doc/BRIEF.md
# Corner-Turning Vector Data Buffer

This block sits beside a string of SIMD processing units and gives each unit one buffer slot. A host-side port moves whole words in or out, one slot per accepted transfer. It is bit-parallel and word-serial, and an internal pointer steps through the slots. An array-side port moves the buffer's contents the other way, a bit-plane at a time. In every cycle of an exchange, each slot offers one bit position to its unit and takes that unit's register bit in return. All slots move together and advance one bit position per cycle.

The exchange is a swap. New operands go into the array's registers while the previous results come out into the buffer, in the same pass. The host port can then read the results and load the next batch while the array computes. While an exchange is running, a busy signal holds off host transfers. An exchange cannot start while a host burst has stopped partway through the slots.

Top module: `ctb_top`

## Requirements
- R1: After reset the slot pointer is 0, `ext_ready` is 1, `xchg_busy` and `xchg_done` are 0, and every slot reads back as zero.
- R2: A host transfer is accepted on a clock edge where `ext_valid` and `ext_ready` are both 1. An accepted write (`ext_write`=1) stores `ext_wdata` into the slot named by `ext_slot`, and the pointer then advances by one.
- R3: The pointer goes from the last slot (`NUM_SLOTS`-1) back to slot 0 after an accepted transfer.
- R4: An accepted read (`ext_write`=0) returns the addressed slot's word on `ext_rdata`, with `ext_rvalid` high for one cycle, in the cycle after acceptance. The pointer then advances by one.
- R5: `xchg_start` is accepted only when no exchange is running, the pointer is 0 and `ext_valid` is 0. Any other start request is ignored and `xchg_busy` stays 0.
- R6: An accepted start raises `xchg_busy` for exactly `WORD_W` cycles. In the k-th of those cycles (k from 0), `plane_idx` equals (`xchg_base`+k) mod `REG_W`, and `plane_out[s]` carries bit k of the word that slot s held before the exchange.
- R7: In the k-th exchange cycle, each slot s stores `plane_in[s]` into its bit k. After the exchange, slot s holds the register bits taken from the array, and the array has received the slot's old bits.
- R8: While `xchg_busy` is 1, `ext_ready` is 0. No host transfer is accepted and the pointer does not move.
- R9: `xchg_done` is high for exactly one cycle, the cycle after the last bit-plane, and `xchg_busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_valid | input | 1 | Host transfer request |
| ext_write | input | 1 | 1 = write slot, 0 = read slot |
| ext_wdata | input | WORD_W | Word to store |
| ext_ready | output | 1 | Host transfer can be accepted |
| ext_rvalid | output | 1 | Read data present |
| ext_rdata | output | WORD_W | Read word |
| ext_slot | output | log2(NUM_SLOTS) | Current slot pointer |
| xchg_start | input | 1 | Request a bit-plane exchange |
| xchg_base | input | log2(REG_W) | Register bit that meets buffer bit 0 |
| xchg_busy | output | 1 | Exchange in progress; bit-plane valid |
| xchg_done | output | 1 | One-cycle completion pulse |
| plane_idx | output | log2(REG_W) | Register bit position for this plane |
| plane_out | output | NUM_SLOTS | Buffer bit per slot, to the array |
| plane_in | input | NUM_SLOTS | Register bit per unit, from the array |

## Verification
Several properties are checked on every cycle: the busy window is exactly `WORD_W` cycles long, `plane_idx` steps by one with modulo wrap, and the done pulse follows the busy fall. They also cover the start gate on pointer and request, the hold-off of host transfers and the pointer's step and wrap. Some behaviour only the bench scenarios can show: whether data lands in the correct slot, whether each plane carries the pre-exchange bits, and whether the buffer and the model registers really swap contents. The bench covers this with a base offset that wraps past the register top and a second, distinct base.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } ext_op_e;
endpackage

// File: rtl/ctb_slot.sv
module ctb_slot #(
   parameter int WORD_W = 32,
   localparam int BIT_AW = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              swap_en,
   input  logic [BIT_AW-1:0] bit_sel,
   input  logic              swap_in,
   output logic [WORD_W-1:0] word,
   output logic              swap_out
);
   logic [WORD_W-1:0] store_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (we) begin
         store_q <= wdata;
      end else if (swap_en) begin
         store_q[bit_sel] <= swap_in;
      end
   end

   assign word     = store_q;
   assign swap_out = store_q[bit_sel];
endmodule

// File: rtl/ctb_host_port.sv
module ctb_host_port
   import ctb_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int WORD_W    = 32,
   parameter bit READ_REG  = 1'b1,
   localparam int SLOT_AW  = $clog2(NUM_SLOTS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ext_valid,
   input  logic                              ext_write,
   input  logic [WORD_W-1:0]                 ext_wdata,
   input  logic                              blocked,
   input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  slot_words,
   output logic                              ext_ready,
   output logic                              ext_rvalid,
   output logic [WORD_W-1:0]                 ext_rdata,
   output logic [SLOT_AW-1:0]                ext_slot,
   output logic [NUM_SLOTS-1:0]              slot_we,
   output logic [WORD_W-1:0]                 slot_wdata,
   output logic                              burst_open
);
   localparam logic [SLOT_AW-1:0] LAST_SLOT = SLOT_AW'(NUM_SLOTS - 1);

   logic [SLOT_AW-1:0] ptr_q;
   logic               take;
   logic               take_rd;
   ext_op_e            op;

   assign op        = ext_op_e'(ext_write);
   assign ext_ready = !blocked;
   assign take      = ext_valid && ext_ready;
   assign take_rd   = take && (op == OP_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (take) begin
         ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
      end
   end

   always_comb begin
      slot_we = '0;
      if (take && (op == OP_WRITE)) begin
         slot_we[ptr_q] = 1'b1;
      end
   end

   assign slot_wdata = ext_wdata;
   assign ext_slot   = ptr_q;
   assign burst_open = (ptr_q != '0);

   generate
      if (READ_REG) begin : g_rd_reg
         logic              rvalid_q;
         logic [WORD_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rvalid_q <= 1'b0;
               rdata_q  <= '0;
            end else begin
               rvalid_q <= take_rd;
               if (take_rd) begin
                  rdata_q <= slot_words[ptr_q];
               end
            end
         end
         assign ext_rvalid = rvalid_q;
         assign ext_rdata  = rdata_q;
      end else begin : g_rd_comb
         assign ext_rvalid = take_rd;
         assign ext_rdata  = slot_words[ptr_q];
      end
   endgenerate
endmodule

// File: rtl/ctb_xchg_seq.sv
module ctb_xchg_seq #(
   parameter int WORD_W = 32,
   parameter int REG_W  = 64,
   localparam int BIT_AW = $clog2(WORD_W),
   localparam int IDX_AW = $clog2(REG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              start_ok,
   input  logic [IDX_AW-1:0] base,
   output logic              busy,
   output logic              done,
   output logic [BIT_AW-1:0] bit_sel,
   output logic [IDX_AW-1:0] plane_idx
);
   localparam logic [BIT_AW-1:0] LAST_BIT = BIT_AW'(WORD_W - 1);

   logic              busy_q;
   logic              done_q;
   logic [BIT_AW-1:0] k_q;
   logic [IDX_AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         k_q    <= '0;
         base_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            if (k_q == LAST_BIT) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               k_q    <= '0;
            end else begin
               k_q <= k_q + 1'b1;
            end
         end else if (start_req && start_ok) begin
            busy_q <= 1'b1;
            k_q    <= '0;
            base_q <= base;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign bit_sel   = k_q;
   assign plane_idx = base_q + IDX_AW'(k_q);
endmodule

// File: rtl/ctb_top.sv
module ctb_top #(
   parameter int NUM_SLOTS = 16,
   parameter int WORD_W    = 32,
   parameter int REG_W     = 64,
   parameter bit READ_REG  = 1'b1,
   localparam int SLOT_AW  = $clog2(NUM_SLOTS),
   localparam int IDX_AW   = $clog2(REG_W),
   localparam int BIT_AW   = $clog2(WORD_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ext_valid,
   input  logic                 ext_write,
   input  logic [WORD_W-1:0]    ext_wdata,
   output logic                 ext_ready,
   output logic                 ext_rvalid,
   output logic [WORD_W-1:0]    ext_rdata,
   output logic [SLOT_AW-1:0]   ext_slot,
   input  logic                 xchg_start,
   input  logic [IDX_AW-1:0]    xchg_base,
   output logic                 xchg_busy,
   output logic                 xchg_done,
   output logic [IDX_AW-1:0]    plane_idx,
   output logic [NUM_SLOTS-1:0] plane_out,
   input  logic [NUM_SLOTS-1:0] plane_in
);
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("ctb_top: NUM_SLOTS must be at least 2");
   end
   if (WORD_W < 2 || (1 << BIT_AW) != WORD_W) begin : g_bad_word
      $error("ctb_top: WORD_W must be a power of two, at least 2");
   end
   if ((1 << IDX_AW) != REG_W || REG_W < WORD_W) begin : g_bad_reg
      $error("ctb_top: REG_W must be a power of two not below WORD_W");
   end

   logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_words;
   logic [NUM_SLOTS-1:0]             slot_we;
   logic [WORD_W-1:0]                slot_wdata;
   logic                             burst_open;
   logic [BIT_AW-1:0]                bit_sel;
   logic                             start_ok;

   ctb_host_port #(
      .NUM_SLOTS (NUM_SLOTS),
      .WORD_W    (WORD_W),
      .READ_REG  (READ_REG)
   ) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_valid  (ext_valid),
      .ext_write  (ext_write),
      .ext_wdata  (ext_wdata),
      .blocked    (xchg_busy),
      .slot_words (slot_words),
      .ext_ready  (ext_ready),
      .ext_rvalid (ext_rvalid),
      .ext_rdata  (ext_rdata),
      .ext_slot   (ext_slot),
      .slot_we    (slot_we),
      .slot_wdata (slot_wdata),
      .burst_open (burst_open)
   );

   assign start_ok = !burst_open && !ext_valid;

   ctb_xchg_seq #(
      .WORD_W (WORD_W),
      .REG_W  (REG_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (xchg_start),
      .start_ok  (start_ok),
      .base      (xchg_base),
      .busy      (xchg_busy),
      .done      (xchg_done),
      .bit_sel   (bit_sel),
      .plane_idx (plane_idx)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      ctb_slot #(
         .WORD_W (WORD_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (slot_we[s]),
         .wdata    (slot_wdata),
         .swap_en  (xchg_busy),
         .bit_sel  (bit_sel),
         .swap_in  (plane_in[s]),
         .word     (slot_words[s]),
         .swap_out (plane_out[s])
      );
   end
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
   parameter int NUM_SLOTS = 16,
   parameter int WORD_W    = 32,
   parameter int REG_W     = 64,
   localparam int SLOT_AW  = $clog2(NUM_SLOTS),
   localparam int IDX_AW   = $clog2(REG_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ext_valid,
   input logic               ext_ready,
   input logic [SLOT_AW-1:0] ext_slot,
   input logic               xchg_busy,
   input logic               xchg_done,
   input logic [IDX_AW-1:0]  plane_idx
);
   logic [31:0] busy_cnt;
   logic        acc;

   assign acc = ext_valid && ext_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)          busy_cnt <= '0;
      else if (xchg_busy)  busy_cnt <= busy_cnt + 1;
      else                 busy_cnt <= '0;
   end

   // R2: pointer steps by one on an accepted transfer below the last slot
   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ext_slot != SLOT_AW'(NUM_SLOTS - 1)) |=> ext_slot == $past(ext_slot) + 1'b1);

   // R3: pointer wraps to zero from the last slot
   p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ext_slot == SLOT_AW'(NUM_SLOTS - 1)) |=> ext_slot == '0);

   // R5: exchange begins only from slot zero with no host request
   p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xchg_busy) |-> ($past(ext_slot) == '0 && !$past(ext_valid)));

   // R6: busy window never exceeds WORD_W cycles
   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_busy |-> busy_cnt < WORD_W);

   // R6: busy window is exactly WORD_W cycles
   p_busy_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xchg_busy) |-> $past(busy_cnt) == WORD_W - 1);

   // R6: plane index steps by one, modulo REG_W
   p_plane_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_busy && $past(xchg_busy)) |-> plane_idx == IDX_AW'($past(plane_idx) + 1'b1));

   // R8: host is held off during an exchange
   p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_busy |-> !ext_ready);

   // R8: pointer does not move across an exchange cycle
   p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_busy |=> $stable(ext_slot));

   // R9: done follows the last busy cycle
   p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_done |-> (!xchg_busy && $past(xchg_busy)));

   // R9: every busy fall produces done
   p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xchg_busy) |-> xchg_done);
endmodule

bind ctb_top ctb_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .WORD_W    (WORD_W),
   .REG_W     (REG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_valid (ext_valid),
   .ext_ready (ext_ready),
   .ext_slot  (ext_slot),
   .xchg_busy (xchg_busy),
   .xchg_done (xchg_done),
   .plane_idx (plane_idx)
);

// File: tb/ctb_top_test.sv
module ctb_top_test;
   localparam int N  = 16;
   localparam int W  = 32;
   localparam int RW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_valid = 1'b0;
   logic          ext_write = 1'b0;
   logic [W-1:0]  ext_wdata = '0;
   logic          ext_ready;
   logic          ext_rvalid;
   logic [W-1:0]  ext_rdata;
   logic [3:0]    ext_slot;
   logic          xchg_start = 1'b0;
   logic [5:0]    xchg_base = '0;
   logic          xchg_busy;
   logic          xchg_done;
   logic [5:0]    plane_idx;
   logic [N-1:0]  plane_out;
   logic [N-1:0]  plane_in;

   logic [RW-1:0] arr [N];
   logic [W-1:0]  loaded [N];
   int            compared = 0;
   int            mismatched = 0;
   bit            finished = 1'b0;

   always #10 clk = ~clk;

   ctb_top uut (
      .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_write(ext_write),
      .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rvalid(ext_rvalid),
      .ext_rdata(ext_rdata), .ext_slot(ext_slot), .xchg_start(xchg_start),
      .xchg_base(xchg_base), .xchg_busy(xchg_busy), .xchg_done(xchg_done),
      .plane_idx(plane_idx), .plane_out(plane_out), .plane_in(plane_in)
   );

   // model of the array's data registers
   always_comb begin
      for (int s = 0; s < N; s++) plane_in[s] = arr[s][plane_idx];
   end
   always @(posedge clk) begin
      if (xchg_busy) begin
         for (int s = 0; s < N; s++) arr[s][plane_idx] <= plane_out[s];
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [W-1:0] w);
      @(negedge clk);
      ext_valid = 1'b1; ext_write = 1'b1; ext_wdata = w;
      @(negedge clk);
      ext_valid = 1'b0;
   endtask

   task automatic do_read(output logic [W-1:0] r, output logic v);
      @(negedge clk);
      ext_valid = 1'b1; ext_write = 1'b0;
      @(negedge clk);
      ext_valid = 1'b0;
      r = ext_rdata; v = ext_rvalid;
   endtask

   task automatic t_reset;
      logic [W-1:0] r; logic v;
      chk("R1 slot", 64'(ext_slot), 64'd0);
      chk("R1 ready", 64'(ext_ready), 64'd1);
      chk("R1 busy", 64'(xchg_busy), 64'd0);
      chk("R1 done", 64'(xchg_done), 64'd0);
      for (int s = 0; s < N; s++) begin
         do_read(r, v);
         chk("R1 zero word", 64'(r), 64'd0);
         chk("R4 rvalid", 64'(v), 64'd1);
      end
      chk("R3 wrap after reads", 64'(ext_slot), 64'd0);
   endtask

   task automatic t_load;
      for (int s = 0; s < N; s++) begin
         loaded[s] = $urandom;
         do_write(loaded[s]);
         chk("R2 pointer step", 64'(ext_slot), 64'((s + 1) % N));
      end
      chk("R3 wrap after writes", 64'(ext_slot), 64'd0);
   endtask

   task automatic t_readback;
      logic [W-1:0] r; logic v;
      for (int s = 0; s < N; s++) begin
         do_read(r, v);
         chk("R4 read word", 64'(r), 64'(loaded[s]));
         chk("R4 rvalid", 64'(v), 64'd1);
      end
      @(negedge clk);
      chk("R4 rvalid single", 64'(ext_rvalid), 64'd0);
   endtask

   task automatic t_refuse;
      logic [W-1:0] r; logic v;
      do_write(32'h1234_5678);
      xchg_start = 1'b1;
      @(negedge clk);
      xchg_start = 1'b0;
      chk("R5 refused mid-burst", 64'(xchg_busy), 64'd0);
      for (int s = 1; s < N; s++) do_write(32'hA5A5_0000 | 32'(s));
      // start together with a host request: must be refused
      ext_valid = 1'b1; ext_write = 1'b0; xchg_start = 1'b1;
      @(negedge clk);
      ext_valid = 1'b0; xchg_start = 1'b0;
      chk("R5 refused with request", 64'(xchg_busy), 64'd0);
      chk("R5 read taken instead", 64'(ext_slot), 64'd1);
      for (int s = 1; s < N; s++) do_read(r, v);
      chk("R3 wrap", 64'(ext_slot), 64'd0);
   endtask

   task automatic t_exchange(input logic [5:0] base);
      logic [RW-1:0] arr_pre [N];
      logic [RW-1:0] exp_reg;
      logic [W-1:0]  exp_word;
      logic [W-1:0]  r; logic v;
      for (int s = 0; s < N; s++) arr[s] = {$urandom, $urandom};
      t_load();
      for (int s = 0; s < N; s++) arr_pre[s] = arr[s];
      xchg_base = base; xchg_start = 1'b1;
      @(negedge clk);
      xchg_start = 1'b0;
      chk("R6 busy", 64'(xchg_busy), 64'd1);
      chk("R8 ready low", 64'(ext_ready), 64'd0);
      ext_valid = 1'b1; ext_write = 1'b1; ext_wdata = 32'hDEAD_BEEF;
      for (int k = 0; k < W; k++) begin
         logic [N-1:0] exp_plane;
         for (int s = 0; s < N; s++) exp_plane[s] = loaded[s][k];
         chk("R6 plane_idx", 64'(plane_idx), 64'((base + k) % RW));
         chk("R6 plane_out", 64'(plane_out), 64'(exp_plane));
         chk("R6 busy held", 64'(xchg_busy), 64'd1);
         @(negedge clk);
      end
      chk("R9 done", 64'(xchg_done), 64'd1);
      chk("R9 busy low", 64'(xchg_busy), 64'd0);
      chk("R8 pointer held", 64'(ext_slot), 64'd0);
      ext_valid = 1'b0;
      @(negedge clk);
      chk("R9 done single", 64'(xchg_done), 64'd0);
      for (int s = 0; s < N; s++) begin
         exp_reg = arr_pre[s];
         for (int k = 0; k < W; k++) begin
            exp_word[k] = arr_pre[s][(base + k) % RW];
            exp_reg[(base + k) % RW] = loaded[s][k];
         end
         chk("R7 register side", arr[s], exp_reg);
         do_read(r, v);
         chk("R7 buffer side", 64'(r), 64'(exp_word));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_readback();
      t_refuse();
      t_exchange(6'd40);
      t_exchange(6'd3);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule